// File: doc/BRIEF.md
# Serial-operand radix-2 butterfly

This block performs one radix-2 decimation-in-time butterfly on signed fixed-point complex samples. For operands `a` (even) and `b` (odd) and a twiddle `w`, it produces `(a + b·w)/2` and `(a − b·w)/2`. Both results are rounded. Halving the results keeps a long chain of stages from overflowing.

The operands arrive one after another on a single data port. The twiddle's real and imaginary parts arrive with them on a separate narrow port. The complex product `b·w` is built from only two real multipliers, which work for two cycles on the same held operand. The two results also leave on a single port, one per cycle.

A per-butterfly order control chooses whether the sum or the difference leaves first. Two units that write into the same pair of memories can use opposite orders, so they never target the same memory in the same cycle. The unit accepts a new butterfly every two cycles, so its output can run continuously.

Top module: `bfly2_serial`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `out_valid` is low.
- R2: A butterfly is two back-to-back cycles with `in_valid` high. The first beat carries `b` on `in_re`/`in_im` and the twiddle real part on `tw`. The second beat carries `a` and the twiddle imaginary part. Data is signed 18-bit and the twiddle is signed Q1.16, so 65536 represents 1.0.
- R3: If the first beat of a butterfly is presented in cycle N, its first result is at the outputs in cycle N+8 and its second result in cycle N+9.
- R4: The sum result equals `(a + p + 1) >>> 1` for the real and imaginary parts separately, where `p` is the rounded product of R6.
- R5: The difference result equals `(a − p + 1) >>> 1` for the real and imaginary parts separately.
- R6: The product is computed as re = bR·wR − bI·wI and im = bI·wR + bR·wI. Each part is rounded half-up to an integer, as `(x + 32768) >>> 16`.
- R7: `diff_first` is sampled with the first beat. When it is 0, the sum leaves first and then the difference. When it is 1, the difference leaves first and then the sum.
- R8: Butterflies may follow each other with no gap. `out_valid` is then high in every cycle, and each butterfly always produces exactly two result beats.
- R9: With w = 1 (wR = 65536, wI = 0) the product equals `b`. With w = −j (wR = 0, wI = −65536) the product equals bI − j·bR.
- R10: Cycles with `in_valid` low start nothing. Outside the two result cycles of a butterfly, `out_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand beat present |
| in_re | input | 18 | Operand real part (b, then a) |
| in_im | input | 18 | Operand imaginary part (b, then a) |
| tw | input | 18 | Twiddle part, Q1.16 (real, then imaginary) |
| diff_first | input | 1 | Result order for this butterfly, taken with the first beat |
| out_valid | output | 1 | Result beat present |
| out_re | output | 18 | Result real part |
| out_im | output | 18 | Result imaginary part |

## Verification
Every result is due at a fixed cycle: the first beat 8 cycles after the butterfly's first operand beat, the second beat one cycle later. The driver stamps each expected beat with its due cycle, taken from a free-running cycle count, and pushes it into the scoreboard. The monitor samples at the falling edge and compares data and arrival cycle together, so a result that is early, late, swapped or spurious counts as a mismatch. The stimulus covers w = 1, w = −j, rounding halfway points, both orders, gapless streams and idle gaps.

// File: rtl/bfly2_serial.sv
module bfly2_serial #(
  parameter int DW  = 18,
  parameter int TW  = 18,
  parameter int LAT = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_re,
  input  logic [DW-1:0] in_im,
  input  logic [TW-1:0] tw,
  input  logic          diff_first,
  output logic          out_valid,
  output logic [DW-1:0] out_re,
  output logic [DW-1:0] out_im
);
  localparam int FB  = TW - 2;
  localparam int PW  = DW + TW;
  localparam int CW  = PW + 1;
  localparam int SW  = DW + 2;
  localparam int PAD = LAT - 5;
  localparam int PL  = 4 * DW + 2;
  localparam logic signed [CW-1:0] HALF = CW'(1) <<< (FB - 1);

  logic                 ph, ord0, v1, ord1, v2, ord2, v3, ord3;
  logic signed [DW-1:0] b_re, b_im, a_re, a_im, op_re, op_im;
  logic signed [PW-1:0] m_re, m_im, p1_re, p1_im;
  logic signed [CW-1:0] full_re, full_im, sh_re, sh_im;
  logic signed [DW:0]   pr_re, pr_im;
  logic signed [SW-1:0] s_re, s_im, d_re, d_im;
  logic [DW-1:0]        sum_re, sum_im, dif_re, dif_im;
  logic [PL-1:0]        pipe [PAD+1];
  logic [2*DW-1:0]      second;
  logic                 pend;

  assign op_re   = ph ? b_re : $signed(in_re);
  assign op_im   = ph ? b_im : $signed(in_im);
  assign full_re = CW'(p1_re) - CW'(m_im);
  assign full_im = CW'(p1_im) + CW'(m_re);
  assign sh_re   = (full_re + HALF) >>> FB;
  assign sh_im   = (full_im + HALF) >>> FB;
  assign s_re    = SW'(a_re) + SW'(pr_re) + SW'(1);
  assign s_im    = SW'(a_im) + SW'(pr_im) + SW'(1);
  assign d_re    = SW'(a_re) - SW'(pr_re) + SW'(1);
  assign d_im    = SW'(a_im) - SW'(pr_im) + SW'(1);
  assign pipe[0] = {v3, ord3, sum_re, sum_im, dif_re, dif_im};

  always_ff @(posedge clk) begin
    m_re <= PW'(op_re) * PW'($signed(tw));
    m_im <= PW'(op_im) * PW'($signed(tw));
    if (in_valid && !ph) begin
      b_re <= $signed(in_re);
      b_im <= $signed(in_im);
    end
    if (in_valid && ph) begin
      a_re  <= $signed(in_re);
      a_im  <= $signed(in_im);
      p1_re <= m_re;
      p1_im <= m_im;
    end
    pr_re  <= sh_re[DW:0];
    pr_im  <= sh_im[DW:0];
    sum_re <= s_re[DW:1];
    sum_im <= s_im[DW:1];
    dif_re <= d_re[DW:1];
    dif_im <= d_im[DW:1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= 1'b0; ord0 <= 1'b0;
      v1 <= 1'b0; ord1 <= 1'b0;
      v2 <= 1'b0; ord2 <= 1'b0;
      v3 <= 1'b0; ord3 <= 1'b0;
    end else begin
      if (in_valid) ph <= ~ph;
      if (in_valid && !ph) ord0 <= diff_first;
      v1   <= in_valid && ph;
      ord1 <= ord0;
      v2   <= v1;
      ord2 <= ord1;
      v3   <= v2;
      ord3 <= ord2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 1; i <= PAD; i++) pipe[i] <= '0;
    end else begin
      for (int i = 0; i < PAD; i++) pipe[i+1] <= pipe[i];
    end
  end

  logic            t_v, t_o;
  logic [2*DW-1:0] t_sum, t_dif;
  assign {t_v, t_o, t_sum, t_dif} = pipe[PAD];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      pend      <= 1'b0;
    end else begin
      out_valid <= t_v || pend;
      pend      <= t_v;
    end
  end

  always_ff @(posedge clk) begin
    if (t_v) begin
      {out_re, out_im} <= t_o ? t_dif : t_sum;
      second           <= t_o ? t_sum : t_dif;
    end else if (pend) begin
      {out_re, out_im} <= second;
    end
  end
endmodule

// File: rtl/bfly2_serial_chk.sv
module bfly2_serial_chk #(
  parameter int LAT = 8
) (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic out_valid
);
  logic           iph, oph;
  logic [LAT-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iph <= 1'b0;
      oph <= 1'b0;
      sr  <= '0;
    end else begin
      if (in_valid)  iph <= ~iph;
      if (out_valid) oph <= ~oph;
      sr <= {sr[LAT-2:0], in_valid && !iph};
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);

  // R2
  in_pair_chk: assert property (@(posedge clk) disable iff (!rst_n) iph |-> in_valid);

  // R3
  first_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sr[LAT-1] |-> (out_valid && !oph));

  // R10
  no_stray_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !oph) |-> sr[LAT-1]);

  // R8
  pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> !oph);
endmodule

bind bfly2_serial bfly2_serial_chk #(.LAT(LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid)
);

// File: tb/bfly2_serial_bench.sv
module bfly2_serial_bench;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        in_valid = 1'b0, diff_first = 1'b0;
  logic [17:0] in_re = '0, in_im = '0, tw = '0;
  logic        out_valid;
  logic [17:0] out_re, out_im;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 1'b0;
  logic [17:0] q_re[$], q_im[$];
  int          q_due[$];
  string       q_tag[$];

  bfly2_serial u_bfly2_serial (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
    .tw(tw), .diff_first(diff_first), .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic longint rnd16(longint x);
    return (x + 64'sd32768) >>> 16;
  endfunction

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic fly(int ar, int ai, int br, int bi, int wr, int wi, bit df, string tag);
    longint pr, pi, sr, si, dr, di;
    pr = rnd16(longint'(br) * wr - longint'(bi) * wi);
    pi = rnd16(longint'(bi) * wr + longint'(br) * wi);
    sr = (ar + pr + 1) >>> 1;  si = (ai + pi + 1) >>> 1;
    dr = (ar - pr + 1) >>> 1;  di = (ai - pi + 1) >>> 1;
    in_valid = 1'b1; in_re = br[17:0]; in_im = bi[17:0]; tw = wr[17:0]; diff_first = df;
    if (df) begin
      q_re.push_back(dr[17:0]); q_im.push_back(di[17:0]);
      q_re.push_back(sr[17:0]); q_im.push_back(si[17:0]);
    end else begin
      q_re.push_back(sr[17:0]); q_im.push_back(si[17:0]);
      q_re.push_back(dr[17:0]); q_im.push_back(di[17:0]);
    end
    q_due.push_back(cyc + 8); q_due.push_back(cyc + 9);
    q_tag.push_back(tag); q_tag.push_back(tag);
    @(posedge clk); #1;
    in_re = ar[17:0]; in_im = ai[17:0]; tw = wi[17:0]; diff_first = ~df;
    @(posedge clk); #1;
    in_valid = 1'b0; in_re = '0; in_im = '0; tw = '0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  function automatic int rv(int lim);
    return int'($urandom_range(0, 2 * lim)) - lim;
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done && out_valid) begin
      if (q_re.size() == 0) begin
        check(1'b0, "R10", "unexpected out_valid", 1, 0);
      end else begin
        logic [17:0] er, ei;
        int due;
        string tg;
        er = q_re.pop_front(); ei = q_im.pop_front();
        due = q_due.pop_front(); tg = q_tag.pop_front();
        n_chk++;
        if (out_re !== er || out_im !== ei || cyc != due) begin
          n_bad++;
          $display("FAIL %s R3/R4/R5: actual (%0d,%0d)@%0d expected (%0d,%0d)@%0d", tg,
                   $signed(out_re), $signed(out_im), cyc, $signed(er), $signed(ei), due);
        end
      end
    end
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    @(negedge clk);
    check(out_valid === 1'b0, "R1", "out_valid in reset", out_valid, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0, "R1", "out_valid after release", out_valid, 0);
    @(posedge clk); #1;

    // R9: unity twiddle, both orders (R7)
    fly(1000, -2000, 300, 401, 65536, 0, 1'b0, "R9 w=1");
    fly(-777, 12345, -5001, 3, 65536, 0, 1'b1, "R9 w=1 R7");
    idle(12);
    // R9: w = -j
    fly(20000, -15, 1234, -4321, 0, -65536, 1'b0, "R9 w=-j");
    fly(-3, 7, -32000, 31999, 0, -65536, 1'b1, "R9 w=-j R7");
    idle(12);
    // R6: halfway rounding of the product, odd sums
    fly(3, -3, 1, -1, 32768, 0, 1'b0, "R6 half");
    fly(0, 1, -1, 1, 32768, 32768, 1'b1, "R6 half neg");
    fly(5, 5, 3, 3, 98304, -98304, 1'b0, "R6 1.5");
    idle(12);
    // R2 gap test with R10 idle watch
    fly(100, 200, 300, 400, 46341, -46341, 1'b0, "R2");
    idle(14);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(out_valid === 1'b0, "R10", "idle out_valid", out_valid, 0);
    end
    @(posedge clk); #1;
    // R8: gapless stream with random data, twiddles and orders (R4 R5)
    for (int i = 0; i < 40; i++)
      fly(rv(32767), rv(32767), rv(32767), rv(32767), rv(65536), rv(65536),
          1'($urandom_range(0, 1)), "R8 R4 R5");
    idle(6);
    for (int i = 0; i < 10; i++) begin
      fly(rv(30000), rv(30000), rv(30000), rv(30000), rv(65536), rv(65536), 1'b1, "R7 R10");
      idle(i % 4);
    end
    idle(16);
    check(q_re.size() == 0, "R3", "results outstanding", q_re.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule